// File: doc/BRIEF.md
# Serial Audio Transmit and Receive Engine

This block moves audio samples between parallel words and a three-wire serial audio bus. The bus has a bit clock, a frame clock that picks the channel (low means left, high means right), and one data line in each direction. The engine pops sample words from an external transmit queue and shifts them out MSB first. It also assembles incoming bits into words and pushes them into an external receive queue. Every channel slot on the bus is 32 bit clocks long. The sample sits at the top of the slot, and the slot positions after the sample are sent as zero.

As a clock master, the engine toggles its own bit clock once for each pulse of an external bit-clock enable, and it flips the frame clock every 32 bit clocks. As a clock slave, it brings the bit clock, the frame clock and the receive data in through two-flop synchronisers and follows their edges. The sample width, the framing style, mute, mono capture and per-channel zero-cross detection are all chosen at run time through static configuration inputs. The queues, the clock dividers and the register interface are outside this block.

Top module: `audio_serial_engine`

## Requirements
- R1: `width_sel` sets the sample width W: 0 gives 8 bits, 1 gives 16, 2 gives 24 and 3 gives 32. The transmitter sends the low W bits of the queue word MSB first at the top of a 32-bit slot and fills the rest of the slot with zeros. A received word holds the W captured bits right-aligned, with zero above them.
- R2: With `fmt_msbj`=0 (standard framing), the MSB of a slot is driven one bit clock after the frame-clock edge, and the first bit after that edge is the tail of the previous slot. With `fmt_msbj`=1 (MSB-justified framing), the MSB is driven on the same falling edge that moves the frame clock.
- R3: In master mode (`slave_mode`=0, `en_all`=1), `bclk_o` toggles on each `bclk_tick` and `lrclk_o` toggles every 32 bit clocks, low for left. In slave mode both outputs stay 0, and the frame timing comes from `bclk_i` and `lrclk_i`.
- R4: While `mute`=1, the transmitter sends zeros in place of the queue data and still pops one word per slot.
- R5: While `mono`=1, only right-channel words are pushed to the receive queue, and `rx_right` is 1 on every push.
- R6: When a word is loaded for a channel whose zero-cross enable is set, that channel's flag (`zc_left`, `zc_right`) is set if the sent sample's sign bit (bit W-1) differs from that channel's previous sent sample, or if the sample is all zero. A 1 on `zc_clr_left` or `zc_clr_right` clears the flag. A set and a clear in the same cycle leave the flag set.
- R7: `tx_right` is 1 while the word being sent belongs to the right channel and 0 for the left channel.
- R8: `tx_busy` rises in the cycle after a word is popped into the shift register. It falls when a slot starts and the queue has no word left.
- R9: Transmission runs only when `en_all` and `tx_en` are both 1, and reception only when `en_all` and `rx_en` are both 1. With `en_all`=0, `bclk_o` stays 0 and nothing is popped.
- R10: If the queue is empty when a slot starts, that slot is sent as zeros and `tx_underflow` pulses for one cycle instead of `tx_pop`.
- R11: `sd_o` changes only on falling bit-clock edges, and `sd_i` is sampled on rising edges. In loopback, a received word equals the low W bits of the word that was sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_all | input | 1 | Global enable |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| slave_mode | input | 1 | 1 = bus clocks come from outside |
| fmt_msbj | input | 1 | 0 = standard framing, 1 = MSB-justified framing |
| width_sel | input | 2 | Sample width code |
| mute | input | 1 | Send zeros in place of queue data |
| mono | input | 1 | Capture the right channel only |
| zc_en_left | input | 1 | Left zero-cross detect enable |
| zc_en_right | input | 1 | Right zero-cross detect enable |
| zc_clr_left | input | 1 | Write-1 clear of the left flag |
| zc_clr_right | input | 1 | Write-1 clear of the right flag |
| bclk_tick | input | 1 | Bit-clock enable pulse from the divider (master) |
| bclk_i | input | 1 | Bus bit clock (slave) |
| lrclk_i | input | 1 | Bus frame clock (slave) |
| sd_i | input | 1 | Serial receive data |
| bclk_o | output | 1 | Bit clock driven in master mode |
| lrclk_o | output | 1 | Frame clock driven in master mode |
| sd_o | output | 1 | Serial transmit data |
| tx_data | input | 32 | Head word of the transmit queue |
| tx_empty | input | 1 | Transmit queue empty |
| tx_pop | output | 1 | Pop pulse to the transmit queue |
| tx_underflow | output | 1 | Slot started with the queue empty |
| rx_data | output | 32 | Captured word |
| rx_right | output | 1 | Captured word is from the right channel |
| rx_push | output | 1 | Push pulse to the receive queue |
| tx_right | output | 1 | Channel of the word being sent |
| tx_busy | output | 1 | Transmit shift path is busy |
| zc_left | output | 1 | Left zero-cross flag |
| zc_right | output | 1 | Right zero-cross flag |

## Verification
Detecting a zero crossing and clearing the flag by software can land in the same cycle. The bench provokes this by waiting for the cycle in which an empty-queue slot start loads an all-zero left sample, then raising `zc_clr_left` for exactly that cycle. The check passes only if `zc_left` reads 1 afterwards, because the set must win. A later lone clear pulse must then bring the flag to 0.

// File: rtl/audio_serial_engine.sv
module audio_serial_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_all,
  input  logic        tx_en,
  input  logic        rx_en,
  input  logic        slave_mode,
  input  logic        fmt_msbj,
  input  logic [1:0]  width_sel,
  input  logic        mute,
  input  logic        mono,
  input  logic        zc_en_left,
  input  logic        zc_en_right,
  input  logic        zc_clr_left,
  input  logic        zc_clr_right,
  input  logic        bclk_tick,
  input  logic        bclk_i,
  input  logic        lrclk_i,
  input  logic        sd_i,
  output logic        bclk_o,
  output logic        lrclk_o,
  output logic        sd_o,
  input  logic [31:0] tx_data,
  input  logic        tx_empty,
  output logic        tx_pop,
  output logic        tx_underflow,
  output logic [31:0] rx_data,
  output logic        rx_right,
  output logic        rx_push,
  output logic        tx_right,
  output logic        tx_busy,
  output logic        zc_left,
  output logic        zc_right
);

  function automatic logic [31:0] low_mask(input logic [1:0] w);
    case (w)
      2'd0:    low_mask = 32'h0000_00FF;
      2'd1:    low_mask = 32'h0000_FFFF;
      2'd2:    low_mask = 32'h00FF_FFFF;
      default: low_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  logic       bclk_q, lr_cur, bclk_prev;
  logic [4:0] bcnt;
  logic [1:0] bsync, lsync, dsync;

  wire run_tx = en_all & tx_en;
  wire run_rx = en_all & rx_en;

  // slave-side synchronisers
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bsync <= '0; lsync <= '0; dsync <= '0; bclk_prev <= 1'b0;
    end else begin
      bsync <= {bsync[0], bclk_i};
      lsync <= {lsync[0], lrclk_i};
      dsync <= {dsync[0], sd_i};
      bclk_prev <= bsync[1];
    end

  wire s_rise  = bsync[1] & ~bclk_prev;
  wire s_fall  = ~bsync[1] & bclk_prev;
  wire m_rise  = bclk_tick & ~bclk_q;
  wire m_fall  = bclk_tick & bclk_q;
  wire rise_ev = en_all & (slave_mode ? s_rise : m_rise);
  wire fall_ev = en_all & (slave_mode ? s_fall : m_fall);

  wire lr_next    = slave_mode ? lsync[1] : ((bcnt == 5'd31) ? ~lr_cur : lr_cur);
  wire slot_start = fall_ev & (lr_next != lr_cur);

  // master clock generation and frame position
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bclk_q <= 1'b0; bcnt <= 5'd31; lr_cur <= 1'b1;
    end else if (!en_all) begin
      bclk_q <= 1'b0; bcnt <= 5'd31; lr_cur <= 1'b1;
    end else begin
      if (slave_mode)     bclk_q <= 1'b0;
      else if (bclk_tick) bclk_q <= ~bclk_q;
      if (fall_ev) begin
        bcnt   <= bcnt + 5'd1;
        lr_cur <= lr_next;
      end
    end

  assign bclk_o  = bclk_q;
  assign lrclk_o = en_all & ~slave_mode & lr_cur;

  // transmit path
  wire [31:0] wmask   = low_mask(width_sel);
  wire [4:0]  pad     = {~width_sel, 3'b000};
  wire [31:0] sample  = (mute | tx_empty) ? 32'd0 : (tx_data & wmask);
  wire [31:0] aligned = sample << pad;
  wire        load    = slot_start & run_tx;

  assign tx_pop       = load & ~tx_empty;
  assign tx_underflow = load & tx_empty;

  logic [31:0] shreg;
  logic        tail, psign_l, psign_r;
  wire         cur_bit = load ? aligned[31] : shreg[31];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0; tail <= 1'b0; sd_o <= 1'b0; tx_right <= 1'b0; tx_busy <= 1'b0;
    end else if (!run_tx) begin
      shreg <= '0; tail <= 1'b0; sd_o <= 1'b0; tx_busy <= 1'b0;
    end else if (fall_ev) begin
      shreg <= load ? (aligned << 1) : (shreg << 1);
      tail  <= cur_bit;
      sd_o  <= fmt_msbj ? cur_bit : tail;
      if (load) begin
        tx_right <= lr_next;
        tx_busy  <= ~tx_empty;
      end
    end

  // zero-cross detection on the sent samples
  wire new_sign = aligned[31];
  wire is_zero  = (aligned == 32'd0);
  wire hit_l = load & ~lr_next & zc_en_left  & ((new_sign != psign_l) | is_zero);
  wire hit_r = load &  lr_next & zc_en_right & ((new_sign != psign_r) | is_zero);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      psign_l <= 1'b0; psign_r <= 1'b0; zc_left <= 1'b0; zc_right <= 1'b0;
    end else begin
      if (load && !lr_next) psign_l <= new_sign;
      if (load &&  lr_next) psign_r <= new_sign;
      zc_left  <= hit_l | (zc_left  & ~zc_clr_left);
      zc_right <= hit_r | (zc_right & ~zc_clr_right);
    end

  // receive path
  logic [31:0] acc;
  logic        rx_lr, armed;
  wire         rx_bit    = slave_mode ? dsync[1] : sd_i;
  wire         rx_bound  = rise_ev & (lr_cur != rx_lr);
  wire [31:0]  acc_in    = {acc[30:0], rx_bit};
  wire [31:0]  done_word = fmt_msbj ? acc : acc_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc <= '0; rx_lr <= 1'b1; armed <= 1'b0;
      rx_push <= 1'b0; rx_data <= '0; rx_right <= 1'b0;
    end else if (!run_rx) begin
      acc <= '0; rx_lr <= 1'b1; armed <= 1'b0; rx_push <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      if (rise_ev) begin
        acc   <= acc_in;
        rx_lr <= lr_cur;
      end
      if (rx_bound) begin
        armed <= 1'b1;
        if (armed && (!mono || rx_lr)) begin
          rx_push  <= 1'b1;
          rx_data  <= done_word >> pad;
          rx_right <= rx_lr;
        end
      end
    end

  assert_busy_after_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_pop));
  assert_slave_clock_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && $past(slave_mode)) |-> !bclk_o);
  assert_mono_right_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && mono && $past(mono)) |-> rx_right);
  assert_zc_left_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zc_left) |-> $past(zc_en_left));
  assert_zc_right_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zc_right) |-> $past(zc_en_right));
  assert_data_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sd_o) && $past(run_tx) && !$past(slave_mode)) |-> $fell(bclk_o));
  assert_halt_no_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_all |-> !tx_pop);

endmodule

// File: tb/tb_audio_serial_engine.sv
module tb_audio_serial_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic en_all = 0, tx_en = 0, rx_en = 0, slave_mode = 0, fmt_msbj = 0, mute = 0, mono = 0;
  logic [1:0] width_sel = 0;
  logic zc_en_left = 0, zc_en_right = 0, zc_clr_left = 0, zc_clr_right = 0;
  logic bclk_tick = 0, bclk_i = 0, lrclk_i = 0, sd_drv = 0, loop = 1;
  logic bclk_o, lrclk_o, sd_o, tx_pop, tx_underflow, rx_right, rx_push, tx_right, tx_busy, zc_left, zc_right;
  logic [31:0] rx_data;
  logic [31:0] q [0:15];
  logic [31:0] rxw [0:15];
  logic        rxr [0:15];
  int head, tail, rcnt, udf_cnt, nchk, nerr;
  logic qclr = 0, busy_seen, sd_seen;

  wire [31:0] tx_data  = q[head[3:0]];
  wire        tx_empty = (head == tail);
  wire        sd_i     = loop ? sd_o : sd_drv;

  audio_serial_engine dut (.*);

  always @(posedge clk) bclk_tick <= ~bclk_tick;

  always @(posedge clk)
    if (qclr) begin
      head <= 0; rcnt <= 0; udf_cnt <= 0; busy_seen <= 0; sd_seen <= 0;
    end else begin
      if (tx_pop) head <= head + 1;
      if (tx_underflow) udf_cnt <= udf_cnt + 1;
      if (tx_busy) busy_seen <= 1;
      if (sd_o) sd_seen <= 1;
      if (rx_push && rcnt < 15) begin
        rxw[rcnt] <= rx_data; rxr[rcnt] <= rx_right; rcnt <= rcnt + 1;
      end
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(input logic [1:0] w);
    return (w == 3) ? 32'hFFFF_FFFF : ((32'd1 << (8 * (w + 1))) - 1);
  endfunction

  task automatic setup(input logic [1:0] w, input logic f, input logic mu, input logic mo,
                       input logic sl, input logic te, input logic re);
    @(negedge clk);
    en_all = 0; qclr = 1;
    width_sel = w; fmt_msbj = f; mute = mu; mono = mo; slave_mode = sl;
    tx_en = te; rx_en = re; loop = !sl; zc_en_left = 0; zc_en_right = 0;
    tail = 0;
    repeat (3) @(negedge clk);
    qclr = 0;
  endtask

  task automatic push(input logic [31:0] d);
    q[tail[3:0]] = d; tail++;
  endtask

  task automatic wait_rx(input int n);
    for (int t = 0; t < 6000 && rcnt < n; t++) @(posedge clk);
    #1;
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk("R3 reset bclk_o", bclk_o, 0);
    chk("R9 reset tx_pop", tx_pop, 0);
    chk("R8 reset tx_busy", tx_busy, 0);
    chk("R6 reset zc flags", {zc_left, zc_right}, 0);
  endtask

  task automatic test_loop(input logic [1:0] w, input logic f);
    logic [31:0] ws [4];
    logic [31:0] al;
    ws = '{32'hA1B2C3D4, 32'h5E6F7081, 32'h13572468, 32'hFEDCBA98};
    setup(w, f, 0, 0, 0, 1, 1);
    for (int i = 0; i < 4; i++) push(ws[i]);
    al = (ws[0] & msk(w)) << (32 - 8 * (w + 1));
    en_all = 1;
    @(negedge lrclk_o); #1;
    chk("R7 left slot tx_right", tx_right, 0);
    @(posedge bclk_o); #1;
    chk("R2 first slot bit", sd_o, f ? al[31] : 1'b0);
    @(posedge bclk_o); #1;
    chk("R2 second slot bit", sd_o, f ? al[30] : al[31]);
    @(posedge lrclk_o); #1;
    chk("R7 right slot tx_right", tx_right, 1);
    wait_rx(4);
    for (int i = 0; i < 4; i++) begin
      chk("R1 R11 loopback word", rxw[i], ws[i] & msk(w));
      chk("R11 loopback channel", rxr[i], i % 2);
    end
  endtask

  task automatic test_mute;
    setup(1, 0, 1, 0, 0, 1, 1);
    for (int i = 0; i < 4; i++) push(32'h0000_7A7A + i);
    en_all = 1;
    wait_rx(4);
    for (int i = 0; i < 4; i++) chk("R4 muted word", rxw[i], 0);
    chk("R4 queue consumed", head, 4);
  endtask

  task automatic test_mono;
    setup(1, 1, 0, 1, 0, 1, 1);
    push(32'h1111); push(32'h2222); push(32'h3333); push(32'h4444);
    en_all = 1;
    wait_rx(2);
    chk("R5 mono first", rxw[0], 32'h2222);
    chk("R5 mono second", rxw[1], 32'h4444);
    chk("R5 mono channels", {rxr[0], rxr[1]}, 2'b11);
  endtask

  task automatic test_underflow;
    setup(1, 0, 0, 0, 0, 1, 1);
    push(32'h1234);
    en_all = 1;
    wait_rx(2);
    chk("R10 left word", rxw[0], 32'h1234);
    chk("R10 empty slot zeros", rxw[1], 0);
    chk("R10 underflow pulsed", udf_cnt > 0, 1);
    chk("R8 busy was set", busy_seen, 1);
    chk("R8 busy cleared", tx_busy, 0);
  endtask

  task automatic test_zc;
    setup(1, 1, 0, 0, 0, 1, 1);
    zc_en_left = 1; zc_en_right = 1;
    push(32'h0100); push(32'h0001); push(32'h8000); push(32'h0002);
    en_all = 1;
    while (head < 2) @(posedge clk);
    repeat (5) @(posedge clk); #1;
    chk("R6 no crossing yet", {zc_left, zc_right}, 0);
    while (head < 4) @(posedge clk);
    repeat (5) @(posedge clk); #1;
    chk("R6 left sign change", zc_left, 1);
    chk("R6 right steady", zc_right, 0);
    @(negedge clk); zc_clr_left = 1; @(negedge clk); zc_clr_left = 0; #1;
    chk("R6 write-1 clear", zc_left, 0);
    while (!(tx_underflow && lrclk_o)) @(negedge clk);
    zc_clr_left = 1;
    @(posedge clk); #1;
    zc_clr_left = 0;
    chk("R6 set beats clear", zc_left, 1);
    @(negedge clk); zc_clr_left = 1; @(negedge clk); zc_clr_left = 0; #1;
    chk("R6 clear after collision", zc_left, 0);
  endtask

  task automatic test_enables;
    setup(1, 0, 0, 0, 0, 0, 1);
    push(32'h5A5A); push(32'hA5A5);
    en_all = 1;
    repeat (600) @(posedge clk); #1;
    chk("R9 tx disabled no pop", head, 0);
    chk("R9 tx disabled line low", sd_seen, 0);
    @(negedge clk); en_all = 0; tx_en = 1; rx_en = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (bclk_o) begin chk("R9 global off bclk", bclk_o, 0); break; end
    end
    chk("R9 global off no pop", head, 0);
    setup(1, 0, 0, 0, 0, 1, 0);
    push(32'h5A5A);
    en_all = 1;
    repeat (600) @(posedge clk); #1;
    chk("R9 rx disabled no push", rcnt, 0);
    chk("R9 tx runs", head, 1);
  endtask

  task automatic sbit(input logic lr, input logic b);
    bclk_i = 0; lrclk_i = lr; sd_drv = b;
    repeat (4) @(posedge clk); #1;
    bclk_i = 1;
    repeat (4) @(posedge clk); #1;
  endtask

  task automatic test_slave;
    logic [15:0] wv [3];
    wv = '{16'h1234, 16'hBEEF, 16'h0000};
    setup(1, 1, 0, 0, 1, 0, 1);
    lrclk_i = 1; bclk_i = 0;
    en_all = 1;
    repeat (6) @(posedge clk); #1;
    for (int s = 0; s < 3; s++)
      for (int p = 0; p < 32; p++) sbit(s % 2, p < 16 ? wv[s][15 - p] : 1'b0);
    sbit(1, 0);
    repeat (10) @(posedge clk); #1;
    chk("R3 slave left word", rxw[0], 32'h1234);
    chk("R3 slave right word", rxw[1], 32'hBEEF);
    chk("R3 slave outputs low", {bclk_o, lrclk_o}, 0);
    en_all = 0; bclk_i = 0; lrclk_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    nchk = 0; nerr = 0; tail = 0;
    qclr = 1;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    test_reset;
    test_loop(0, 0);
    test_loop(1, 1);
    test_loop(2, 0);
    test_loop(3, 1);
    test_loop(3, 0);
    test_mute;
    test_mono;
    test_underflow;
    test_zc;
    test_enables;
    test_slave;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule